// File: doc/BRIEF.md
# IDE DMA Transfer Progress Tracker

This block sits between a scatter DMA channel and an IDE device model and keeps the position of a transfer that arrives in pieces. Before a transfer, a configuration pulse loads the mode, the command and the starting counters. The mode is either disk mode, which counts 512-byte sectors, or packet mode, which counts 2048-byte blocks and keeps a byte offset inside the current block. After that, each DMA start pulse hands over one piece as an address and a byte length. The block turns that piece into one request for the storage back end, waits for the back end to answer, and then moves its counters forward.

Each time a request finishes, and also when a piece begins, the block checks whether the whole transfer is done. If it is, the status byte shows ready and seek-complete and a one-cycle interrupt is raised. When there are no bytes left to launch, a one-cycle DMA-end pulse hands control back to the DMA channel. An error answer from the back end ends the piece at once. The block then sets error status, raises the interrupt and pulses DMA-end, and it leaves the counters as they were. The back end is a plain valid/ready request followed by a single-cycle response. No data passes through this block.

Top module: `ide_xfer_tracker`

## Requirements
- R1: After a synchronous reset, all counters, the status byte, the pending DMA address, the request fields, `irq`, `dma_end`, `req_valid` and `busy` are zero.
- R2: `cfg_load` and `dma_start` take effect only while `busy` is low; a pulse of either while busy changes nothing. `cfg_load` loads the mode (`cfg_pkt`: 0 disk, 1 packet), the command, the sector, count, block address and packet size, and it clears the byte index and the status byte.
- R3: In disk mode, a request of N bytes that completes without error adds ceil(N/512) to `cur_sector` and subtracts the same amount from `cur_count`.
- R4: In the check cycle, the transfer counts as complete in disk mode when `cur_count` is zero, and in packet mode when `pkt_left` is zero or negative. When it is complete, `status` becomes 8'h50 (ready bit 6, seek bit 4) and `irq` pulses for one cycle.
- R5: In packet mode, a completed request of N bytes adds N to the byte index. `cur_lba` then grows by the index divided by 2048, and `cur_index` keeps the index modulo 2048.
- R6: In packet mode, each completed request subtracts its byte count from the signed `pkt_left`.
- R7: In packet mode, `req_lba` is `cur_lba`*4 + `cur_index`/512, given in 512-byte units, and `req_op` is read (0). In disk mode, `req_lba` is `cur_sector`.
- R8: A `dma_start` accepted in idle enters the check cycle on the next edge. When the check cycle finds a pending length of zero, it pulses `dma_end` and returns to idle. When the pending length is not zero, it copies that length to `req_bytes`, copies the pending address to `req_addr`, advances `dma_next_addr` by the length, clears the pending length and raises `req_valid` from the next cycle.
- R9: In disk mode, `req_op` is the loaded command (0 read, 1 write, 2 trim), and each launched piece clears `cur_index`.
- R10: An error response (`rsp_valid` with `rsp_err` while a response is awaited) sets `status` to 8'h41 (ready bit 6, error bit 0), pulses `irq` and `dma_end`, returns to idle, zeroes `req_bytes` and leaves every counter unchanged.
- R11: `req_valid` and the request fields hold steady until `req_ready` is seen. A response is accepted only in a cycle after the request was taken, and a response at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load configuration (idle only) |
| cfg_pkt | input | 1 | Mode: 0 disk sectors, 1 packet blocks |
| cfg_op | input | 2 | Disk command: 0 read, 1 write, 2 trim |
| cfg_sector | input | SEC_W | Starting sector (disk mode) |
| cfg_count | input | CNT_W | Sectors to transfer (disk mode) |
| cfg_lba | input | SEC_W | Starting 2048-byte block (packet mode) |
| cfg_pkt_size | input | PKT_W | Packet bytes to transfer, signed |
| dma_start | input | 1 | Begin one DMA piece (idle only) |
| dma_addr | input | ADDR_W | Memory address of the piece |
| dma_len | input | LEN_W | Byte length of the piece |
| req_valid | output | 1 | Back-end request pending |
| req_ready | input | 1 | Back end takes the request |
| req_op | output | 2 | Request type: 0 read, 1 write, 2 trim |
| req_lba | output | SEC_W | Request address in 512-byte units |
| req_addr | output | ADDR_W | Memory address of the request |
| req_bytes | output | LEN_W | Byte length of the current request |
| rsp_valid | input | 1 | Back-end response |
| rsp_err | input | 1 | Response reports an error |
| busy | output | 1 | A piece is in progress |
| dma_next_addr | output | ADDR_W | DMA address after the launched bytes |
| cur_sector | output | SEC_W | Current sector (disk mode) |
| cur_count | output | CNT_W | Remaining sectors (disk mode) |
| cur_lba | output | SEC_W | Current block (packet mode) |
| cur_index | output | 11 | Byte offset within the block |
| pkt_left | output | PKT_W | Remaining packet bytes, signed |
| status | output | 8 | Device status byte |
| irq | output | 1 | One-cycle device interrupt |
| dma_end | output | 1 | One-cycle end-of-DMA pulse |

## Verification
The hardest case to reach from the ports is a stray response that arrives while a request is still waiting for `req_ready`. If that response were taken, it would either abort the piece or move the counters. To provoke it, the bench's back-end responder always returns an error response in the first cycle it sees a request and only then grants the request two cycles later. The block-offset carry is driven by packet pieces whose lengths are not multiples of 2048, so the index crosses a block boundary partway through. A zero-length piece issued after the count has already reached zero covers the path where completion and DMA-end happen in the same check cycle.

// File: rtl/ixt_pkg.sv
package ixt_pkg;

    localparam int ATA_SECT_BYTES = 512;
    localparam int PKT_BLK_BYTES  = 2048;
    localparam int ATA_SHIFT      = $clog2(ATA_SECT_BYTES);
    localparam int PKT_SHIFT      = $clog2(PKT_BLK_BYTES);
    localparam int UNITS_LOG      = PKT_SHIFT - ATA_SHIFT;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_TRIM  = 2'd2
    } xfer_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CHECK = 2'd1,
        PH_REQ   = 2'd2,
        PH_WAIT  = 2'd3
    } phase_e;

    // Counter control issued by the sequencer each cycle.
    typedef struct packed {
        logic load;
        logic upd;
        logic clr_idx;
    } ctr_cmd_t;

    localparam logic [7:0] SB_READY  = 8'h40;
    localparam logic [7:0] SB_SEEK   = 8'h10;
    localparam logic [7:0] SB_ERR    = 8'h01;
    localparam logic [7:0] STAT_DONE = SB_READY | SB_SEEK;
    localparam logic [7:0] STAT_FAIL = SB_READY | SB_ERR;

    // Whole sectors covered by a byte count, rounded up.
    function automatic logic [31:0] sectors_of(input logic [31:0] nbytes);
        logic [32:0] t;
        t = {1'b0, nbytes} + 33'(ATA_SECT_BYTES - 1);
        return 32'(t >> ATA_SHIFT);
    endfunction

endpackage

// File: rtl/ixt_ata_ctr.sv
module ixt_ata_ctr
    import ixt_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int CNT_W = 16,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctr_cmd_t         cmd,
    input  logic [SEC_W-1:0] cfg_sector,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [LEN_W-1:0] upd_bytes,
    output logic [SEC_W-1:0] sector,
    output logic [CNT_W-1:0] count,
    output logic             zero
);

    logic [31:0] nsec;

    assign nsec = sectors_of(32'(upd_bytes));
    assign zero = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sector <= '0;
            count  <= '0;
        end else if (cmd.load) begin
            sector <= cfg_sector;
            count  <= cfg_count;
        end else if (cmd.upd) begin
            sector <= sector + SEC_W'(nsec);
            count  <= count - CNT_W'(nsec);
        end
    end

endmodule

// File: rtl/ixt_pkt_ctr.sv
module ixt_pkt_ctr
    import ixt_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int PKT_W = 32,
    parameter int LEN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  ctr_cmd_t                cmd,
    input  logic [SEC_W-1:0]        cfg_lba,
    input  logic signed [PKT_W-1:0] cfg_size,
    input  logic [LEN_W-1:0]        upd_bytes,
    output logic [SEC_W-1:0]        lba,
    output logic [PKT_SHIFT-1:0]    idx,
    output logic signed [PKT_W-1:0] left,
    output logic                    done,
    output logic [SEC_W-1:0]        req_unit
);

    localparam int SUM_W = ((LEN_W > PKT_SHIFT) ? LEN_W : PKT_SHIFT) + 1;

    logic [SUM_W-1:0] sum;

    assign sum      = SUM_W'(idx) + SUM_W'(upd_bytes);
    assign done     = left[PKT_W-1] || (left == '0);
    assign req_unit = (lba << UNITS_LOG) + SEC_W'(idx >> ATA_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            lba  <= '0;
            idx  <= '0;
            left <= '0;
        end else if (cmd.load) begin
            lba  <= cfg_lba;
            idx  <= '0;
            left <= cfg_size;
        end else if (cmd.upd) begin
            lba  <= lba + SEC_W'(sum >> PKT_SHIFT);
            idx  <= sum[PKT_SHIFT-1:0];
            left <= left - PKT_W'(upd_bytes);
        end else if (cmd.clr_idx) begin
            idx  <= '0;
        end
    end

endmodule

// File: rtl/ixt_ctrl.sv
module ixt_ctrl
    import ixt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic              dma_start,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [LEN_W-1:0]  dma_len,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic              complete,
    output phase_e            ph,
    output ctr_cmd_t          cmd,
    output logic [LEN_W-1:0]  buf_len,
    output logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic [7:0]        status,
    output logic              irq,
    output logic              dma_end
);

    logic [LEN_W-1:0] pend_len;
    logic             launch;
    logic             resp_ok;

    assign launch  = (ph == PH_CHECK) && (pend_len != '0);
    assign resp_ok = (ph == PH_WAIT) && rsp_valid && !rsp_err;

    always_comb begin
        cmd         = '0;
        cmd.load    = (ph == PH_IDLE) && cfg_load;
        cmd.upd     = resp_ok;
        cmd.clr_idx = launch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            pend_len  <= '0;
            buf_len   <= '0;
            req_addr  <= '0;
            next_addr <= '0;
            status    <= '0;
            irq       <= 1'b0;
            dma_end   <= 1'b0;
        end else begin
            irq     <= 1'b0;
            dma_end <= 1'b0;
            if (cmd.load) begin
                status <= '0;
            end
            unique case (ph)
                PH_IDLE: begin
                    if (dma_start) begin
                        next_addr <= dma_addr;
                        pend_len  <= dma_len;
                        buf_len   <= '0;
                        ph        <= PH_CHECK;
                    end
                end
                PH_CHECK: begin
                    if (complete) begin
                        status <= STAT_DONE;
                        irq    <= 1'b1;
                    end
                    if (launch) begin
                        buf_len   <= pend_len;
                        req_addr  <= next_addr;
                        next_addr <= next_addr + ADDR_W'(pend_len);
                        pend_len  <= '0;
                        ph        <= PH_REQ;
                    end else begin
                        dma_end <= 1'b1;
                        ph      <= PH_IDLE;
                    end
                end
                PH_REQ: begin
                    if (req_ready) begin
                        ph <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (rsp_valid) begin
                        if (rsp_err) begin
                            status  <= STAT_FAIL;
                            irq     <= 1'b1;
                            dma_end <= 1'b1;
                            buf_len <= '0;
                            ph      <= PH_IDLE;
                        end else begin
                            ph <= PH_CHECK;
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ide_xfer_tracker.sv
module ide_xfer_tracker
    import ixt_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32,
    parameter int PKT_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_load,
    input  logic                    cfg_pkt,
    input  logic [1:0]              cfg_op,
    input  logic [SEC_W-1:0]        cfg_sector,
    input  logic [CNT_W-1:0]        cfg_count,
    input  logic [SEC_W-1:0]        cfg_lba,
    input  logic signed [PKT_W-1:0] cfg_pkt_size,
    input  logic                    dma_start,
    input  logic [ADDR_W-1:0]       dma_addr,
    input  logic [LEN_W-1:0]        dma_len,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic [1:0]              req_op,
    output logic [SEC_W-1:0]        req_lba,
    output logic [ADDR_W-1:0]       req_addr,
    output logic [LEN_W-1:0]        req_bytes,
    input  logic                    rsp_valid,
    input  logic                    rsp_err,
    output logic                    busy,
    output logic [ADDR_W-1:0]       dma_next_addr,
    output logic [SEC_W-1:0]        cur_sector,
    output logic [CNT_W-1:0]        cur_count,
    output logic [SEC_W-1:0]        cur_lba,
    output logic [PKT_SHIFT-1:0]    cur_index,
    output logic signed [PKT_W-1:0] pkt_left,
    output logic [7:0]              status,
    output logic                    irq,
    output logic                    dma_end
);

    phase_e   phase;
    ctr_cmd_t seq_cmd;
    ctr_cmd_t ata_cmd;
    ctr_cmd_t pkt_cmd;
    logic     mode_q;
    xfer_op_e op_q;
    logic     ata_zero;
    logic     pkt_done;
    logic     complete;
    logic     waiting;
    logic [SEC_W-1:0] pkt_unit;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            op_q   <= OP_READ;
        end else if (seq_cmd.load) begin
            mode_q <= cfg_pkt;
            op_q   <= xfer_op_e'(cfg_op);
        end
    end

    // Route the shared update strobe to the counter set of the active mode.
    always_comb begin
        ata_cmd         = '0;
        ata_cmd.load    = seq_cmd.load;
        ata_cmd.upd     = seq_cmd.upd && !mode_q;
        pkt_cmd         = '0;
        pkt_cmd.load    = seq_cmd.load;
        pkt_cmd.upd     = seq_cmd.upd && mode_q;
        pkt_cmd.clr_idx = seq_cmd.clr_idx && !mode_q;
    end

    assign complete  = mode_q ? pkt_done : ata_zero;
    assign busy      = (phase != PH_IDLE);
    assign req_valid = (phase == PH_REQ);
    assign waiting   = (phase == PH_WAIT);
    assign req_op    = mode_q ? OP_READ : op_q;
    assign req_lba   = mode_q ? pkt_unit : cur_sector;

    ixt_ctrl #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_load  (cfg_load),
        .dma_start (dma_start),
        .dma_addr  (dma_addr),
        .dma_len   (dma_len),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .complete  (complete),
        .ph        (phase),
        .cmd       (seq_cmd),
        .buf_len   (req_bytes),
        .req_addr  (req_addr),
        .next_addr (dma_next_addr),
        .status    (status),
        .irq       (irq),
        .dma_end   (dma_end)
    );

    ixt_ata_ctr #(
        .SEC_W (SEC_W),
        .CNT_W (CNT_W),
        .LEN_W (LEN_W)
    ) u_ata (
        .clk        (clk),
        .rst        (rst),
        .cmd        (ata_cmd),
        .cfg_sector (cfg_sector),
        .cfg_count  (cfg_count),
        .upd_bytes  (req_bytes),
        .sector     (cur_sector),
        .count      (cur_count),
        .zero       (ata_zero)
    );

    ixt_pkt_ctr #(
        .SEC_W (SEC_W),
        .PKT_W (PKT_W),
        .LEN_W (LEN_W)
    ) u_pkt (
        .clk       (clk),
        .rst       (rst),
        .cmd       (pkt_cmd),
        .cfg_lba   (cfg_lba),
        .cfg_size  (cfg_pkt_size),
        .upd_bytes (req_bytes),
        .lba       (cur_lba),
        .idx       (cur_index),
        .left      (pkt_left),
        .done      (pkt_done),
        .req_unit  (pkt_unit)
    );

endmodule

// File: rtl/ixt_chk.sv
module ixt_chk #(
    parameter int SEC_W = 32,
    parameter int CNT_W = 16,
    parameter int LEN_W = 16,
    parameter int PKT_W = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [1:0]              req_op,
    input logic [SEC_W-1:0]        req_lba,
    input logic [LEN_W-1:0]        req_bytes,
    input logic                    rsp_valid,
    input logic                    rsp_err,
    input logic                    busy,
    input logic                    waiting,
    input logic                    mode_q,
    input logic [SEC_W-1:0]        cur_sector,
    input logic [CNT_W-1:0]        cur_count,
    input logic signed [PKT_W-1:0] pkt_left,
    input logic [7:0]              status,
    input logic                    irq,
    input logic                    dma_end
);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_lba)
                                    && $stable(req_bytes) && $stable(req_op));

    p_stray_rsp_r11: assert property (@(posedge clk) disable iff (rst)
        busy && !waiting && rsp_valid |=> $stable(cur_count) && $stable(pkt_left));

    p_end_idle_r8: assert property (@(posedge clk) disable iff (rst)
        dma_end |-> !busy);

    p_abort_r10: assert property (@(posedge clk) disable iff (rst)
        waiting && rsp_valid && rsp_err |=> status == 8'h41 && irq && dma_end
                                            && $stable(cur_count) && $stable(pkt_left));

    p_sector_step_r3: assert property (@(posedge clk) disable iff (rst)
        waiting && rsp_valid && !rsp_err && !mode_q
        |=> (cur_sector - $past(cur_sector))
            == SEC_W'((32'($past(req_bytes)) + 32'd511) >> 9));

    p_irq_status_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status == 8'h50 || status == 8'h41));

endmodule

bind ide_xfer_tracker ixt_chk #(
    .SEC_W (SEC_W),
    .CNT_W (CNT_W),
    .LEN_W (LEN_W),
    .PKT_W (PKT_W)
) u_chk (.*);

// File: tb/sim_ide_xfer_tracker.sv
module sim_ide_xfer_tracker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_load = 1'b0;
    logic        cfg_pkt = 1'b0;
    logic [1:0]  cfg_op = 2'd0;
    logic [31:0] cfg_sector = '0;
    logic [15:0] cfg_count = '0;
    logic [31:0] cfg_lba = '0;
    logic signed [31:0] cfg_pkt_size = '0;
    logic        dma_start = 1'b0;
    logic [31:0] dma_addr = '0;
    logic [15:0] dma_len = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [1:0]  req_op;
    logic [31:0] req_lba;
    logic [31:0] req_addr;
    logic [15:0] req_bytes;
    logic        rsp_valid = 1'b0;
    logic        rsp_err = 1'b0;
    logic        busy;
    logic [31:0] dma_next_addr;
    logic [31:0] cur_sector;
    logic [15:0] cur_count;
    logic [31:0] cur_lba;
    logic [10:0] cur_index;
    logic signed [31:0] pkt_left;
    logic [7:0]  status;
    logic        irq;
    logic        dma_end;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ide_xfer_tracker u0 (.*);

    // ---------------- behavioural reference ----------------
    int          m_ph;          // 0 idle, 1 check, 2 request, 3 awaiting answer
    int          m_mode, m_op;
    logic [31:0] m_sector, m_lba, m_paddr, m_raddr;
    logic [15:0] m_count, m_plen, m_buf;
    int          m_idx;
    int          m_left;
    logic [7:0]  m_status;
    int          m_irq, m_end;
    int          tot, nsec;
    bit          fin;

    always @(posedge clk) begin
        if (rst) begin
            m_ph <= 0; m_mode <= 0; m_op <= 0; m_sector <= 0; m_lba <= 0;
            m_paddr <= 0; m_raddr <= 0; m_count <= 0; m_plen <= 0; m_buf <= 0;
            m_idx <= 0; m_left <= 0; m_status <= 0; m_irq <= 0; m_end <= 0;
        end else begin
            m_irq <= 0;
            m_end <= 0;
            case (m_ph)
                0: begin
                    if (cfg_load) begin
                        m_mode <= int'(cfg_pkt); m_op <= int'(cfg_op);
                        m_sector <= cfg_sector; m_count <= cfg_count;
                        m_lba <= cfg_lba; m_idx <= 0; m_left <= cfg_pkt_size;
                        m_status <= 8'h00;
                    end
                    if (dma_start) begin
                        m_paddr <= dma_addr; m_plen <= dma_len; m_buf <= 0; m_ph <= 1;
                    end
                end
                1: begin
                    fin = (m_mode != 0) ? (m_left <= 0) : (m_count == 0);
                    if (fin) begin m_status <= 8'h50; m_irq <= 1; end
                    if (m_plen == 0) begin
                        m_end <= 1; m_ph <= 0;
                    end else begin
                        m_buf <= m_plen; m_raddr <= m_paddr;
                        m_paddr <= m_paddr + 32'(m_plen); m_plen <= 0;
                        if (m_mode == 0) m_idx <= 0;
                        m_ph <= 2;
                    end
                end
                2: if (req_ready) m_ph <= 3;
                default: begin
                    if (rsp_valid) begin
                        if (rsp_err) begin
                            m_status <= 8'h41; m_irq <= 1; m_end <= 1; m_buf <= 0; m_ph <= 0;
                        end else begin
                            if (m_mode != 0) begin
                                tot = m_idx + int'(m_buf);
                                m_lba <= m_lba + 32'(tot / 2048);
                                m_idx <= tot % 2048;
                                m_left <= m_left - int'(m_buf);
                            end else begin
                                nsec = (int'(m_buf) + 511) / 512;
                                m_sector <= m_sector + 32'(nsec);
                                m_count <= m_count - 16'(nsec);
                            end
                            m_ph <= 1;
                        end
                    end
                end
            endcase
        end
    end

    // ---------------- checking ----------------
    int    n_vec = 0;
    int    n_bad = 0;
    string scen = "R1";

    task automatic cmp(input string field, input string tag,
                       input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s/%s %s: actual %0h expected %0h at %0t",
                     tag, scen, field, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        longint exp_lba;
        exp_lba = (m_mode != 0) ? longint'(32'(m_lba * 4 + 32'(m_idx / 512)))
                                : longint'(m_sector);
        cmp("busy", "R11", busy, m_ph != 0);
        cmp("req_valid", "R11", req_valid, m_ph == 2);
        cmp("req_op", "R9", req_op, (m_mode != 0) ? 0 : m_op);
        cmp("req_lba", "R7", req_lba, exp_lba);
        cmp("req_addr", "R8", req_addr, m_raddr);
        cmp("req_bytes", "R8", req_bytes, m_buf);
        cmp("dma_next_addr", "R8", dma_next_addr, m_paddr);
        cmp("cur_sector", "R3", cur_sector, m_sector);
        cmp("cur_count", "R3", cur_count, m_count);
        cmp("cur_lba", "R5", cur_lba, m_lba);
        cmp("cur_index", "R5", cur_index, m_idx);
        cmp("pkt_left", "R6", pkt_left, m_left);
        cmp("status", "R4", status, m_status);
        cmp("irq", "R4", irq, m_irq);
        cmp("dma_end", "R8", dma_end, m_end);
    endtask

    // ---------------- back-end responder ----------------
    int hold = 0;
    int dly = 0;
    bit pend = 0;
    bit inj_err = 0;

    task automatic step();
        @(negedge clk);
        compare_all();
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        if (req_valid) begin
            hold++;
            if (hold == 1) begin
                // stray error answer while request not yet taken (R11)
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            if (hold >= 3) begin
                req_ready = 1'b1;
                hold = 0;
                pend = 1;
                dly = 2;
            end
        end else if (pend) begin
            if (dly == 0) begin
                rsp_valid = 1'b1;
                rsp_err   = inj_err;
                pend = 0;
            end else begin
                dly--;
            end
        end
    endtask

    task automatic configure(input bit pkt, input logic [1:0] op,
                             input logic [31:0] sec, input logic [15:0] cnt,
                             input logic [31:0] lba, input int size);
        cfg_pkt = pkt; cfg_op = op; cfg_sector = sec; cfg_count = cnt;
        cfg_lba = lba; cfg_pkt_size = size; cfg_load = 1'b1;
        step();
        cfg_load = 1'b0;
        step();
    endtask

    task automatic run_chunk(input logic [31:0] addr, input logic [15:0] len,
                             input bit err, input bit poke);
        inj_err = err; dma_addr = addr; dma_len = len; dma_start = 1'b1;
        step();
        dma_start = 1'b0;
        for (int k = 0; k < 60; k++) begin
            if (dma_end) break;
            if (poke && k == 2) begin
                // R2: both pulses land while busy and must be ignored
                cfg_load = 1'b1; cfg_pkt = ~cfg_pkt; cfg_count = 16'h7777;
                cfg_sector = 32'h5555; dma_start = 1'b1; dma_len = 16'd4;
            end
            step();
            cfg_load = 1'b0;
            dma_start = 1'b0;
        end
        step();
        step();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        scen = "R1";
        step();

        // Disk read with rounding (R3, R9)
        scen = "R3";
        configure(1'b0, 2'd0, 32'd100, 16'd10, 32'd0, 0);
        run_chunk(32'h1000, 16'd1024, 1'b0, 1'b0);
        run_chunk(32'h2000, 16'd700, 1'b0, 1'b0);
        run_chunk(32'h3000, 16'd1, 1'b0, 1'b1);
        scen = "R4";
        run_chunk(32'h4000, 16'd2560, 1'b0, 1'b0);
        // zero-length piece after count is exhausted (R4, R8)
        scen = "R8";
        run_chunk(32'h5000, 16'd0, 1'b0, 1'b0);

        // Disk write and trim (R9)
        scen = "R9";
        configure(1'b0, 2'd1, 32'd7, 16'd3, 32'd0, 0);
        run_chunk(32'h100, 16'd512, 1'b0, 1'b0);
        configure(1'b0, 2'd2, 32'd40, 16'd2, 32'd0, 0);
        run_chunk(32'h200, 16'd1024, 1'b0, 1'b0);

        // Disk error abort (R10)
        scen = "R10";
        configure(1'b0, 2'd0, 32'd300, 16'd4, 32'd0, 0);
        run_chunk(32'h600, 16'd1024, 1'b1, 1'b0);

        // Packet mode with index carry (R5, R6, R7)
        scen = "R5";
        configure(1'b1, 2'd1, 32'd0, 16'd0, 32'd50, 5000);
        run_chunk(32'h8000, 16'd1000, 1'b0, 1'b0);
        scen = "R7";
        run_chunk(32'h9000, 16'd1500, 1'b0, 1'b1);
        scen = "R6";
        run_chunk(32'hA000, 16'd3000, 1'b0, 1'b0);

        // Packet error abort (R10)
        scen = "R10";
        configure(1'b1, 2'd0, 32'd0, 16'd0, 32'd9, 4096);
        run_chunk(32'hB000, 16'd2048, 1'b0, 1'b0);
        run_chunk(32'hC000, 16'd777, 1'b1, 1'b0);

        // Reset mid-flight returns to the zero state (R1)
        scen = "R1";
        configure(1'b0, 2'd0, 32'd11, 16'd9, 32'd0, 0);
        dma_addr = 32'hD000; dma_len = 16'd64; dma_start = 1'b1;
        step();
        dma_start = 1'b0;
        step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        step();
        step();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule